// File: doc/BRIEF.md
# I2C Master Command and Data Queue Port

This block sits between a register bus and the byte engine of an I2C master. Software places command words into a transmit queue through a single command window. Each word is either a byte to send or a read request. For a read request the byte field carries no meaning. The byte engine takes words from the head of the transmit queue and pushes the bytes it receives into a receive queue. Software drains that queue by reading the same command window.

Software can read how many words each queue holds. Each queue has a programmable watermark: one drives a "transmit running low" flag and the other a "receive data waiting" flag, for use as interrupt sources. A read-only parameter word reports both queue depths, so a driver can size its bursts without hard-coding them. Any transfer abort from the engine empties both queues. While the enable register reads 0, both queues are held empty. Dropped pushes and reads of an empty receive queue raise one-cycle error pulses.

Top module: `i2c_cfp_port`

## Requirements
- R1: A write to offset 0x10 with bit 8 clear queues the word {0, wdata[7:0]}. Words leave on `tx_word_o` in the order they were written, and `tx_word_o[8]` is the read flag.
- R2: A write to offset 0x10 with bit 8 set queues a read request presented as 9'h100. The low byte of the write is ignored.
- R3: A read of offset 0x10 returns the oldest received byte in bits [7:0], with the other bits zero, and removes that byte from the receive queue.
- R4: Offset 0x74 reads the transmit queue level and offset 0x78 reads the receive queue level.
- R5: Offset 0xF4 reads TX_DEPTH-1 in bits [23:16] and RX_DEPTH-1 in bits [15:8]. All other bits read zero.
- R6: Offset 0x3C holds the transmit watermark and offset 0x38 holds the receive watermark. Both are 8 bits wide, read back, and reset to 0. `tx_empty_o` is high exactly while the transmit level is at or below the transmit watermark.
- R7: `rx_full_o` is high exactly while the receive level is above the receive watermark.
- R8: An `abort_i` cycle leaves both queue levels at 0 on the next cycle.
- R9: Bit 0 of offset 0x6C is the enable and resets to 0. While it is 0, both queues are emptied and held empty, command writes are dropped, and engine pushes are dropped.
- R10: A command write while the transmit queue is full is dropped. `tx_over_o` pulses high for the one cycle after that write.
- R11: An engine push while the receive queue is full is dropped. `rx_over_o` pulses high for the one cycle after that push.
- R12: A read of offset 0x10 with the receive queue empty returns 0 and leaves the level unchanged. `rx_under_o` pulses high for the one cycle after that read.
- R13: After reset both levels are 0 and `tx_valid_o` is low. `tx_pop_i` removes a word only while `tx_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; a read of 0x10 pops the receive queue |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 9 | Write data; bits [8:0] cover every writable field |
| reg_rdata_o | output | 32 | Read data, combinational from the current address |
| tx_valid_o | output | 1 | Transmit queue holds a word |
| tx_word_o | output | 9 | Head transmit word: bit 8 is the read flag, bits [7:0] the byte |
| tx_pop_i | input | 1 | Engine takes the head transmit word |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_byte_i | input | 8 | Received byte |
| abort_i | input | 1 | Transfer abort; empties both queues |
| tx_empty_o | output | 1 | Transmit level at or below its watermark |
| rx_full_o | output | 1 | Receive level above its watermark |
| tx_over_o | output | 1 | Pulse: command write dropped because the queue was full |
| rx_over_o | output | 1 | Pulse: engine push dropped because the queue was full |
| rx_under_o | output | 1 | Pulse: command window read while the receive queue was empty |

## Verification
The bench builds the block with TX_DEPTH=4 and RX_DEPTH=6. These small, unequal depths let both full conditions and both overflow pulses be reached within a few writes. They also make a swap of the two depth fields in the parameter word, or of the two level registers, show up as a wrong value. With a depth of 4 the transmit watermark can be set just below full, so one pop moves `tx_empty_o` across its boundary. With a depth of 6 the receive watermark can be set at the full level and one below it, so both sides of the strict comparison are checked.

// File: rtl/i2c_cfp_pkg.sv
package i2c_cfp_pkg;
  localparam logic [7:0] OFS_CMD    = 8'h10;
  localparam logic [7:0] OFS_RX_THR = 8'h38;
  localparam logic [7:0] OFS_TX_THR = 8'h3C;
  localparam logic [7:0] OFS_ENA    = 8'h6C;
  localparam logic [7:0] OFS_TX_LVL = 8'h74;
  localparam logic [7:0] OFS_RX_LVL = 8'h78;
  localparam logic [7:0] OFS_PARAM  = 8'hF4;

  localparam int RD_FLAG_BIT = 8;

  typedef struct packed {
    logic       rd;
    logic [7:0] dat;
  } cmd_word_t;
endpackage

// File: rtl/cfp_fifo.sv
module cfp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign dout_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R13: level never exceeds depth
  a_r13_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  // R8: flush leaves queue empty
  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  // R10: push into full queue without pop keeps level
  a_r10_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/cfp_level_flags.sv
module cfp_level_flags #(
  parameter int TX_CW = 4,
  parameter int RX_CW = 4,
  parameter int TH_W  = 8
) (
  input  logic [TX_CW-1:0] tx_level_i,
  input  logic [RX_CW-1:0] rx_level_i,
  input  logic [TH_W-1:0]  tx_thr_i,
  input  logic [TH_W-1:0]  rx_thr_i,
  output logic             tx_low_o,
  output logic             rx_high_o
);
  always_comb begin
    tx_low_o  = int'(tx_level_i) <= int'(tx_thr_i);
    rx_high_o = int'(rx_level_i) >  int'(rx_thr_i);
  end
endmodule

// File: rtl/i2c_cfp_port.sv
module i2c_cfp_port
  import i2c_cfp_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int TH_W     = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [8:0]  reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        tx_valid_o,
  output logic [8:0]  tx_word_o,
  input  logic        tx_pop_i,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        abort_i,
  output logic        tx_empty_o,
  output logic        rx_full_o,
  output logic        tx_over_o,
  output logic        rx_over_o,
  output logic        rx_under_o
);
  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);
  localparam logic [31:0] PARAM_WORD = {8'h00, 8'(TX_DEPTH - 1), 8'(RX_DEPTH - 1), 8'h00};

  logic            en_q;
  logic [TH_W-1:0] tx_thr_q, rx_thr_q;
  logic            tx_over_q, rx_over_q, rx_under_q;
  logic            flush;
  logic            cmd_wr, tx_push, rx_pop_req, rx_push;
  cmd_word_t       tx_in, tx_head;
  logic [TX_CW-1:0] tx_level;
  logic [RX_CW-1:0] rx_level;
  logic            tx_full, tx_mt, rx_full_q, rx_mt;
  logic [7:0]      rx_head;

  assign flush      = abort_i | ~en_q;
  assign cmd_wr     = reg_we_i & (reg_addr_i == OFS_CMD);
  assign tx_push    = cmd_wr & en_q;
  assign rx_pop_req = reg_re_i & (reg_addr_i == OFS_CMD);
  assign rx_push    = rx_push_i & en_q;

  // read request carries no payload
  always_comb begin
    tx_in.rd  = reg_wdata_i[RD_FLAG_BIT];
    tx_in.dat = reg_wdata_i[RD_FLAG_BIT] ? 8'h00 : reg_wdata_i[7:0];
  end

  cfp_fifo #(.WIDTH($bits(cmd_word_t)), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(tx_push), .pop_i(tx_pop_i),
    .din_i(tx_in), .dout_o(tx_head), .count_o(tx_level),
    .full_o(tx_full), .empty_o(tx_mt)
  );

  cfp_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(rx_push), .pop_i(rx_pop_req),
    .din_i(rx_byte_i), .dout_o(rx_head), .count_o(rx_level),
    .full_o(rx_full_q), .empty_o(rx_mt)
  );

  cfp_level_flags #(.TX_CW(TX_CW), .RX_CW(RX_CW), .TH_W(TH_W)) u_flags (
    .tx_level_i(tx_level), .rx_level_i(rx_level),
    .tx_thr_i(tx_thr_q), .rx_thr_i(rx_thr_q),
    .tx_low_o(tx_empty_o), .rx_high_o(rx_full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      tx_thr_q   <= '0;
      rx_thr_q   <= '0;
      tx_over_q  <= 1'b0;
      rx_over_q  <= 1'b0;
      rx_under_q <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          OFS_ENA:    en_q     <= reg_wdata_i[0];
          OFS_TX_THR: tx_thr_q <= reg_wdata_i[TH_W-1:0];
          OFS_RX_THR: rx_thr_q <= reg_wdata_i[TH_W-1:0];
          default: ;
        endcase
      end
      tx_over_q  <= tx_push & tx_full;
      rx_over_q  <= rx_push & rx_full_q;
      rx_under_q <= rx_pop_req & rx_mt;
    end
  end

  always_comb begin
    case (reg_addr_i)
      OFS_CMD:    reg_rdata_o = rx_mt ? 32'h0 : {24'h0, rx_head};
      OFS_RX_THR: reg_rdata_o = 32'(rx_thr_q);
      OFS_TX_THR: reg_rdata_o = 32'(tx_thr_q);
      OFS_ENA:    reg_rdata_o = {31'h0, en_q};
      OFS_TX_LVL: reg_rdata_o = 32'(tx_level);
      OFS_RX_LVL: reg_rdata_o = 32'(rx_level);
      OFS_PARAM:  reg_rdata_o = PARAM_WORD;
      default:    reg_rdata_o = 32'h0;
    endcase
  end

  assign tx_valid_o = ~tx_mt;
  assign tx_word_o  = tx_head;
  assign tx_over_o  = tx_over_q;
  assign rx_over_o  = rx_over_q;
  assign rx_under_o = rx_under_q;

  a_r8_abort_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (tx_level == '0) && (rx_level == '0));
  a_r9_disabled_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (tx_level == '0) && (rx_level == '0));
  a_r10_tx_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && en_q && tx_level == TX_CW'(TX_DEPTH)) |=> tx_over_o);
  a_r11_rx_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && en_q && rx_level == RX_CW'(RX_DEPTH)) |=> rx_over_o);
  a_r12_under_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_req && rx_level == '0) |-> (reg_rdata_o == 32'h0));
  a_r12_under_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_req && rx_level == '0) |=> rx_under_o);
  a_r13_valid_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o == (tx_level != '0));
endmodule

// File: tb/i2c_cfp_port_test.sv
module i2c_cfp_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 4;
  localparam int RXD = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [8:0]  wdata = '0;
  logic [31:0] rdata;
  logic        tx_valid;
  logic [8:0]  tx_word;
  logic        tx_pop = 1'b0, rx_push = 1'b0, abort = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_empty, rx_full, tx_over, rx_over, rx_under;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [8:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  logic       last_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cfp_port #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_valid_o(tx_valid), .tx_word_o(tx_word), .tx_pop_i(tx_pop),
    .rx_push_i(rx_push), .rx_byte_i(rx_byte), .abort_i(abort),
    .tx_empty_o(tx_empty), .rx_full_o(rx_full), .tx_over_o(tx_over),
    .rx_over_o(rx_over), .rx_under_o(rx_under)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [8:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; last_pulse = tx_over;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0; last_pulse = rx_under;
  endtask

  task automatic reg_chk(logic [7:0] a, logic [31:0] exp, string req);
    logic [31:0] d;
    @(negedge clk); addr = a; #1 d = rdata;
    check(d == exp, req, d, exp);
  endtask

  // driver: queue a command and record its expected engine-side word
  task automatic send_cmd(logic [8:0] d, bit expect_queued);
    reg_wr(8'h10, d);
    if (expect_queued) exp_tx.push_back(d[8] ? 9'h100 : {1'b0, d[7:0]});
  endtask

  // monitor: engine pops one word and compares against the scoreboard
  task automatic engine_pop(string req);
    logic [8:0] e;
    @(negedge clk);
    check(tx_valid == 1'b1, {req, " valid"}, tx_valid, 1);
    e = exp_tx.pop_front();
    check(tx_word == e, req, tx_word, e);
    tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic engine_push(logic [7:0] b, bit expect_queued);
    @(negedge clk); rx_push = 1'b1; rx_byte = b;
    @(negedge clk); rx_push = 1'b0; last_pulse = rx_over;
    if (expect_queued) exp_rx.push_back(b);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(tx_valid == 1'b0, "R13 reset valid", tx_valid, 0);
    reg_chk(8'h74, 0, "R4 R13 reset tx level");
    reg_chk(8'h78, 0, "R4 R13 reset rx level");
    check(tx_empty == 1'b1, "R6 reset tx_empty", tx_empty, 1);
    check(rx_full == 1'b0, "R7 reset rx_full", rx_full, 0);
    reg_chk(8'hF4, {8'h00, 8'(TXD-1), 8'(RXD-1), 8'h00}, "R5 param word");
    reg_chk(8'h6C, 0, "R9 enable reset");

    // R9: disabled drops writes and pushes
    send_cmd(9'h0AA, 0);
    engine_push(8'h11, 0);
    reg_chk(8'h74, 0, "R9 tx write dropped while disabled");
    reg_chk(8'h78, 0, "R9 rx push dropped while disabled");

    reg_wr(8'h6C, 9'h001);
    reg_chk(8'h6C, 1, "R9 enable readback");

    // R13: pop on empty queue does nothing
    @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
    reg_chk(8'h74, 0, "R13 pop on empty");

    // R1 R2 fill transmit queue
    send_cmd(9'h0A5, 1);
    send_cmd(9'h03C, 1);
    send_cmd(9'h1FF, 1);
    send_cmd(9'h000, 1);
    reg_chk(8'h74, 4, "R4 tx level full");
    send_cmd(9'h077, 0);
    check(last_pulse == 1'b1, "R10 tx_over pulse", last_pulse, 1);
    @(negedge clk);
    check(tx_over == 1'b0, "R10 tx_over one cycle", tx_over, 0);
    reg_chk(8'h74, 4, "R10 tx level unchanged");

    // R6 watermark
    reg_wr(8'h3C, 9'h003);
    reg_chk(8'h3C, 3, "R6 tx threshold readback");
    check(tx_empty == 1'b0, "R6 tx_empty above threshold", tx_empty, 0);
    engine_pop("R1 first word");
    check(tx_empty == 1'b1, "R6 tx_empty at threshold", tx_empty, 1);
    engine_pop("R1 second word");
    engine_pop("R2 read request word");
    engine_pop("R1 zero data word");
    check(tx_valid == 1'b0, "R13 drained", tx_valid, 0);

    // receive side
    for (int i = 0; i < RXD; i++) engine_push(8'(8'h40 + i*7), 1);
    reg_chk(8'h78, RXD, "R4 rx level full");
    check(rx_full == 1'b1, "R7 rx_full above zero threshold", rx_full, 1);
    reg_wr(8'h38, 9'(RXD));
    reg_chk(8'h38, RXD, "R6 rx threshold readback");
    check(rx_full == 1'b0, "R7 rx_full at threshold", rx_full, 0);
    reg_wr(8'h38, 9'(RXD-1));
    check(rx_full == 1'b1, "R7 rx_full one above threshold", rx_full, 1);
    engine_push(8'hEE, 0);
    check(last_pulse == 1'b1, "R11 rx_over pulse", last_pulse, 1);
    reg_chk(8'h78, RXD, "R11 rx level unchanged");
    for (int i = 0; i < RXD; i++) begin
      logic [7:0] e;
      e = exp_rx.pop_front();
      reg_rd(8'h10, d);
      check(d == {24'h0, e}, "R3 rx byte order", d, {24'h0, e});
    end
    reg_chk(8'h78, 0, "R3 rx drained");
    reg_rd(8'h10, d);
    check(d == 0, "R12 empty read value", d, 0);
    check(last_pulse == 1'b1, "R12 rx_under pulse", last_pulse, 1);
    reg_chk(8'h78, 0, "R12 level unchanged");

    // R8 abort
    send_cmd(9'h012, 0);
    send_cmd(9'h034, 0);
    engine_push(8'h56, 0);
    engine_push(8'h78, 0);
    reg_chk(8'h74, 2, "R8 tx level before abort");
    @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
    reg_chk(8'h74, 0, "R8 tx flushed");
    reg_chk(8'h78, 0, "R8 rx flushed");

    // R9 disable flushes
    send_cmd(9'h099, 0);
    engine_push(8'h9A, 0);
    reg_wr(8'h6C, 9'h000);
    reg_chk(8'h74, 0, "R9 tx flushed on disable");
    reg_chk(8'h78, 0, "R9 rx flushed on disable");

    // after re-enable, queue works again
    reg_wr(8'h6C, 9'h001);
    send_cmd(9'h1A0, 1);
    engine_pop("R2 read request after re-enable");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule